// File: doc/BRIEF.md
# Page Permission and Reference/Change Checker

This block judges one leaf page-table entry against one memory access. From the entry's authority bits, its privileged bit, the processor's problem-state bit, the problem-state flag of the translation index, the scope of the check and a 64-bit authority mask, it works out which of read, write and execute may be granted. It then decides whether the access faults on protection, and why. A separate flag reports an access whose reference or change bits are not yet set.

A fault on missing reference or change bits is only reported. The entry is never rewritten, and updating it is left to software. The block is fed by a table walker, which presents the leaf entry together with `req_valid`. Exactly one clock later the registered verdict appears with `res_valid`. Walking the tree and raising interrupts happen elsewhere.

Top module: `pte_perm_rc_check`

## Requirements
- R1: A result appears with `res_valid` high exactly one cycle after `req_valid` is sampled high. Without a request `res_valid` is low and every result output keeps its previous value.
- R2: The access type is encoded as 0 for load, 1 for store, 2 for instruction fetch and 3 for load. A load needs read, a store needs write and a fetch needs execute.
- R3: The entry grants authority through bit 0 (execute), bit 1 (write) and bit 2 (read). Bit 3 marks the entry as privileged.
- R4: Entry bits [5:4] hold the attribute. When they equal 2'b11 (non-idempotent I/O) and the access is a fetch, the result is a protection fault with cause 2'b10 (guarded no-execute), whatever the permissions are. Loads and stores to such pages are not faulted for that reason.
- R5: In a process-scoped check (`partition_scope` low), a privileged entry accessed while `problem_state` is high is granted no permission at all.
- R6: Otherwise, when `idx_problem` is high, or the entry is privileged, or the check is partition-scoped, the granted set equals the entry's authority bits.
- R7: In every remaining case the entry's authority is narrowed by the mask. The key is entry bits [13:9]. Mask bit 2*key set removes read and mask bit 2*key+1 set removes write. Execute is never removed by the mask.
- R8: When the required permission is not granted, `prot_fault` rises. A fetch reports cause 2'b10 and a load or store reports cause 2'b01. Without a protection fault the cause is 2'b00.
- R9: Entry bit 8 is the reference bit and bit 7 is the change bit. A store needs both set, and a load or fetch needs the reference bit only. If the needed bits are missing, `rc_fault` rises.
- R10: A protection fault takes priority, so `rc_fault` is low whenever `prot_fault` is high.
- R11: While `rst` is high, and after it until the first request, `res_valid`, the permissions, `prot_fault`, `fault_cause` and `rc_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Entry and access qualifiers are valid this cycle |
| pte | input | 64 | Leaf page-table entry |
| acc_type | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| problem_state | input | 1 | Processor runs in problem (user) state |
| idx_problem | input | 1 | The translation index is a problem-state index |
| partition_scope | input | 1 | Check is partition-scoped rather than process-scoped |
| auth_mask | input | 64 | Authority mask, two disable bits per key |
| res_valid | output | 1 | Result valid, one cycle after the request |
| perm_rd | output | 1 | Read granted |
| perm_wr | output | 1 | Write granted |
| perm_ex | output | 1 | Execute granted |
| prot_fault | output | 1 | Protection fault |
| fault_cause | output | 2 | 2'b01 protection, 2'b10 guarded no-execute |
| rc_fault | output | 1 | Reference/change bits missing for this access |

## Verification
The bench drives each of the three ways the granted set can be formed. A privileged entry in problem state tells the empty-set path apart from the others. The index flag, the privileged bit and partition scope each select the direct path alone. Unprivileged supervisor accesses use keys 0, 5 and 31 to show that the mask removes read or write but never execute. Fetches to I/O pages with full authority separate the attribute guard from the permission check, and loads to the same pages show that the guard applies to fetches only. Reference and change patterns on granted and denied accesses show what each access type needs and that the protection fault wins. Idle gaps between requests show that the result is held.

// File: rtl/perm_chk_pkg.sv
package perm_chk_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  localparam logic [1:0] CAUSE_NONE  = 2'b00;
  localparam logic [1:0] CAUSE_PROT  = 2'b01;
  localparam logic [1:0] CAUSE_GUARD = 2'b10;

endpackage

// File: rtl/auth_mask_lookup.sv
module auth_mask_lookup
  import perm_chk_pkg::*;
#(
  parameter int KEY_W = 5,
  parameter int AMR_W = 2 * (2 ** KEY_W)
) (
  input  logic [KEY_W-1:0] key,
  input  logic [AMR_W-1:0] mask,
  output perm_t            mask_perm
);
  localparam int NKEYS = 2 ** KEY_W;

  perm_t per_key [NKEYS];

  // One permission set per key, then a plain selector on the entry's key.
  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    assign per_key[k].rd = ~mask[2*k];
    assign per_key[k].wr = ~mask[2*k+1];
    assign per_key[k].ex = 1'b1;
  end

  always_comb begin
    mask_perm = per_key[key];
  end
endmodule

// File: rtl/perm_resolve.sv
module perm_resolve
  import perm_chk_pkg::*;
(
  input  perm_t entry_auth,
  input  logic  entry_priv,
  input  logic  problem_state,
  input  logic  idx_problem,
  input  logic  partition_scope,
  input  perm_t mask_perm,
  output perm_t granted
);
  logic deny_all;
  logic direct;

  always_comb begin
    deny_all = !partition_scope && entry_priv && problem_state;
    direct   = idx_problem || entry_priv || partition_scope;
    if (deny_all) begin
      granted = '0;
    end else if (direct) begin
      granted = entry_auth;
    end else begin
      granted = entry_auth & mask_perm;
    end
  end
endmodule

// File: rtl/fault_judge.sv
module fault_judge
  import perm_chk_pkg::*;
(
  input  logic [1:0] acc_type,
  input  logic       io_page,
  input  perm_t      granted,
  input  logic       ref_bit,
  input  logic       chg_bit,
  output logic       prot_fault,
  output logic [1:0] cause,
  output logic       rc_fault
);
  logic is_fetch;
  logic is_store;
  logic need_ok;
  logic rc_ok;

  always_comb begin
    is_fetch = (acc_type == ACC_FETCH);
    is_store = (acc_type == ACC_STORE);

    unique case (acc_type)
      ACC_FETCH: need_ok = granted.ex;
      ACC_STORE: need_ok = granted.wr;
      default:   need_ok = granted.rd;
    endcase

    rc_ok = ref_bit && (chg_bit || !is_store);

    if (io_page && is_fetch) begin
      prot_fault = 1'b1;
      cause      = CAUSE_GUARD;
    end else if (!need_ok) begin
      prot_fault = 1'b1;
      cause      = is_fetch ? CAUSE_GUARD : CAUSE_PROT;
    end else begin
      prot_fault = 1'b0;
      cause      = CAUSE_NONE;
    end

    rc_fault = !prot_fault && !rc_ok;
  end
endmodule

// File: rtl/pte_perm_rc_check.sv
module pte_perm_rc_check
  import perm_chk_pkg::*;
#(
  parameter int ENTRY_W  = 64,
  parameter int KEY_W    = 5,
  parameter int AMR_W    = 2 * (2 ** KEY_W),
  parameter int EX_BIT   = 0,
  parameter int WR_BIT   = 1,
  parameter int RD_BIT   = 2,
  parameter int PRIV_BIT = 3,
  parameter int ATTR_LSB = 4,
  parameter int CHG_BIT  = 7,
  parameter int REF_BIT  = 8,
  parameter int KEY_LSB  = 9,
  parameter logic [1:0] IO_ATTR = 2'b11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ENTRY_W-1:0] pte,
  input  logic [1:0]         acc_type,
  input  logic               problem_state,
  input  logic               idx_problem,
  input  logic               partition_scope,
  input  logic [AMR_W-1:0]   auth_mask,
  output logic               res_valid,
  output logic               perm_rd,
  output logic               perm_wr,
  output logic               perm_ex,
  output logic               prot_fault,
  output logic [1:0]         fault_cause,
  output logic               rc_fault
);
  perm_t            entry_auth;
  perm_t            mask_perm;
  perm_t            granted;
  logic [KEY_W-1:0] key;
  logic             io_page;
  logic             prot_c;
  logic [1:0]       cause_c;
  logic             rc_c;

  always_comb begin
    entry_auth.rd = pte[RD_BIT];
    entry_auth.wr = pte[WR_BIT];
    entry_auth.ex = pte[EX_BIT];
    key           = pte[KEY_LSB +: KEY_W];
    io_page       = (pte[ATTR_LSB +: 2] == IO_ATTR);
  end

  auth_mask_lookup #(.KEY_W(KEY_W), .AMR_W(AMR_W)) u_mask (
    .key       (key),
    .mask      (auth_mask),
    .mask_perm (mask_perm)
  );

  perm_resolve u_resolve (
    .entry_auth      (entry_auth),
    .entry_priv      (pte[PRIV_BIT]),
    .problem_state   (problem_state),
    .idx_problem     (idx_problem),
    .partition_scope (partition_scope),
    .mask_perm       (mask_perm),
    .granted         (granted)
  );

  fault_judge u_judge (
    .acc_type   (acc_type),
    .io_page    (io_page),
    .granted    (granted),
    .ref_bit    (pte[REF_BIT]),
    .chg_bit    (pte[CHG_BIT]),
    .prot_fault (prot_c),
    .cause      (cause_c),
    .rc_fault   (rc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      perm_rd     <= 1'b0;
      perm_wr     <= 1'b0;
      perm_ex     <= 1'b0;
      prot_fault  <= 1'b0;
      fault_cause <= CAUSE_NONE;
      rc_fault    <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        perm_rd     <= granted.rd;
        perm_wr     <= granted.wr;
        perm_ex     <= granted.ex;
        prot_fault  <= prot_c;
        fault_cause <= cause_c;
        rc_fault    <= rc_c;
      end
    end
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R1

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(perm_rd) && $stable(prot_fault) && $stable(rc_fault)); // R1

  AST_IO_FETCH_GUARD: assert property (@(posedge clk) disable iff (rst)
    req_valid && (pte[ATTR_LSB +: 2] == IO_ATTR) && (acc_type == ACC_FETCH)
    |=> prot_fault && (fault_cause == CAUSE_GUARD)); // R4

  AST_PRIV_USER_EMPTY: assert property (@(posedge clk) disable iff (rst)
    req_valid && !partition_scope && pte[PRIV_BIT] && problem_state
    |=> !perm_rd && !perm_wr && !perm_ex); // R5

  AST_CAUSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot0(fault_cause) && (prot_fault == (fault_cause != 2'b00))); // R8

  AST_PROT_BEFORE_RC: assert property (@(posedge clk) disable iff (rst)
    res_valid && prot_fault |-> !rc_fault); // R10

endmodule

// File: tb/sim_pte_perm_rc_check.sv
module sim_pte_perm_rc_check;
  typedef struct {
    logic       rd, wr, ex, pf, rc;
    logic [1:0] cause;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] pte = '0;
  logic [1:0]  acc_type = 2'd0;
  logic        problem_state = 1'b0;
  logic        idx_problem = 1'b0;
  logic        partition_scope = 1'b0;
  logic [63:0] auth_mask = '0;
  logic        res_valid, perm_rd, perm_wr, perm_ex, prot_fault, rc_fault;
  logic [1:0]  fault_cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t sb[$];
  exp_t last;
  bit have_last = 1'b0;

  always #10 clk = ~clk;

  pte_perm_rc_check u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .pte(pte), .acc_type(acc_type),
    .problem_state(problem_state), .idx_problem(idx_problem),
    .partition_scope(partition_scope), .auth_mask(auth_mask),
    .res_valid(res_valid), .perm_rd(perm_rd), .perm_wr(perm_wr), .perm_ex(perm_ex),
    .prot_fault(prot_fault), .fault_cause(fault_cause), .rc_fault(rc_fault)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Expected verdict worked out from the requirements.
  function automatic exp_t model(logic [63:0] e, logic [1:0] a, logic ps,
                                 logic ip, logic part, logic [63:0] m, string tag);
    exp_t r;
    logic ar, aw, ax, need;
    int k;
    k  = int'(e[13:9]);
    ar = e[2]; aw = e[1]; ax = e[0];
    if (!part && e[3] && ps) begin
      ar = 0; aw = 0; ax = 0;                       // R5
    end else if (!(ip || e[3] || part)) begin
      ar = ar & ~m[2*k]; aw = aw & ~m[2*k+1];      // R7
    end
    r.rd = ar; r.wr = aw; r.ex = ax;
    need = (a == 2'd2) ? ax : (a == 2'd1) ? aw : ar;
    if (a == 2'd2 && e[5:4] == 2'b11) begin
      r.pf = 1; r.cause = 2'b10;
    end else if (!need) begin
      r.pf = 1; r.cause = (a == 2'd2) ? 2'b10 : 2'b01;
    end else begin
      r.pf = 0; r.cause = 2'b00;
    end
    r.rc = !r.pf && !(e[8] && (e[7] || a != 2'd1));
    r.tag = tag;
    return r;
  endfunction

  task automatic send(input logic [63:0] e, input logic [1:0] a, input logic ps,
                      input logic ip, input logic part, input logic [63:0] m,
                      input string tag);
    @(negedge clk);
    pte = e; acc_type = a; problem_state = ps; idx_problem = ip;
    partition_scope = part; auth_mask = m; req_valid = 1'b1;
    sb.push_back(model(e, a, ps, ip, part, m, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      pte = ~64'h0;
      acc_type = 2'd1;
    end
  endtask

  function automatic logic [63:0] mk(logic [4:0] key, logic r, logic c,
                                     logic [1:0] attr, logic priv, logic [2:0] rwx);
    return {50'h0, key, r, c, 1'b0, attr, priv, rwx};
  endfunction

  // Monitor: compares each result against the oldest expected item.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (res_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1", "unexpected res_valid", 8'd1, 8'd0);
        end else begin
          exp_t x;
          x = sb.pop_front();
          check({perm_rd, perm_wr, perm_ex} === {x.rd, x.wr, x.ex}, x.tag, "perm",
                {5'd0, perm_rd, perm_wr, perm_ex}, {5'd0, x.rd, x.wr, x.ex});
          check(prot_fault === x.pf && fault_cause === x.cause, x.tag, "prot/cause",
                {5'd0, prot_fault, fault_cause}, {5'd0, x.pf, x.cause});
          check(rc_fault === x.rc, x.tag, "rc_fault", {7'd0, rc_fault}, {7'd0, x.rc});
          last = x; have_last = 1'b1;
        end
      end else if (have_last) begin
        check({perm_rd, perm_wr, perm_ex, prot_fault, fault_cause, rc_fault} ===
              {last.rd, last.wr, last.ex, last.pf, last.cause, last.rc},
              "R1", "held outputs",
              {1'b0, perm_rd, perm_wr, perm_ex, prot_fault, fault_cause, rc_fault},
              {1'b0, last.rd, last.wr, last.ex, last.pf, last.cause, last.rc});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] m5;
    m5 = 64'h0;
    m5[10] = 1'b1;                // key 5 loses read
    repeat (3) @(negedge clk);
    check({res_valid, perm_rd, perm_wr, perm_ex, prot_fault, fault_cause, rc_fault} == 8'h0,
          "R11", "reset state",
          {res_valid, perm_rd, perm_wr, perm_ex, prot_fault, fault_cause, rc_fault}, 8'h0);
    rst = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0 && perm_rd == 1'b0, "R11", "idle after reset",
          {6'd0, res_valid, perm_rd}, 8'h0);

    // R2 R3 R6: direct authority via partition scope, each access type
    send(mk(0, 1, 1, 2'b00, 0, 3'b111), 2'd0, 0, 0, 1, '1, "R6");
    send(mk(0, 1, 1, 2'b00, 0, 3'b100), 2'd1, 0, 0, 1, '1, "R2");
    send(mk(0, 1, 1, 2'b00, 0, 3'b010), 2'd2, 0, 0, 1, '0, "R8");
    send(mk(0, 1, 1, 2'b00, 0, 3'b001), 2'd3, 0, 0, 1, '0, "R3");
    idle(2);
    // R5: privileged entry in problem state, process scoped
    send(mk(3, 1, 1, 2'b00, 1, 3'b111), 2'd0, 1, 1, 0, '0, "R5");
    // privileged entry in problem state but partition scoped -> direct
    send(mk(3, 1, 1, 2'b00, 1, 3'b111), 2'd1, 1, 0, 1, '1, "R6");
    // idx_problem alone selects direct authority, mask ignored
    send(mk(5, 1, 1, 2'b00, 0, 3'b110), 2'd0, 0, 1, 0, '1, "R6");
    // privileged entry, supervisor: direct, mask ignored
    send(mk(5, 1, 1, 2'b00, 1, 3'b110), 2'd1, 0, 0, 0, '1, "R6");
    // R7: mask narrowing
    send(mk(5, 1, 1, 2'b00, 0, 3'b111), 2'd0, 0, 0, 0, m5, "R7");
    send(mk(5, 1, 1, 2'b00, 0, 3'b111), 2'd1, 0, 0, 0, m5, "R7");
    send(mk(31, 1, 1, 2'b00, 0, 3'b111), 2'd1, 0, 0, 0, 64'h8000_0000_0000_0000, "R7");
    send(mk(31, 1, 1, 2'b00, 0, 3'b111), 2'd2, 0, 0, 0, '1, "R7");
    send(mk(0, 1, 1, 2'b00, 0, 3'b111), 2'd0, 0, 0, 0, 64'h1, "R7");
    idle(3);
    // R4: I/O attribute guard
    send(mk(0, 1, 1, 2'b11, 0, 3'b111), 2'd2, 0, 0, 1, '0, "R4");
    send(mk(0, 1, 1, 2'b11, 0, 3'b111), 2'd0, 0, 0, 1, '0, "R4");
    send(mk(0, 0, 0, 2'b11, 0, 3'b111), 2'd2, 0, 0, 1, '0, "R4");
    send(mk(0, 1, 1, 2'b10, 0, 3'b111), 2'd2, 0, 0, 1, '0, "R4");
    // R9: reference/change
    send(mk(0, 1, 0, 2'b00, 0, 3'b111), 2'd1, 0, 0, 1, '0, "R9");
    send(mk(0, 1, 0, 2'b00, 0, 3'b111), 2'd0, 0, 0, 1, '0, "R9");
    send(mk(0, 0, 1, 2'b00, 0, 3'b111), 2'd2, 0, 0, 1, '0, "R9");
    send(mk(0, 0, 1, 2'b00, 0, 3'b111), 2'd1, 0, 0, 1, '0, "R9");
    // R10: protection fault masks rc fault
    send(mk(0, 0, 0, 2'b00, 0, 3'b101), 2'd1, 0, 0, 1, '0, "R10");
    send(mk(0, 0, 0, 2'b00, 0, 3'b011), 2'd0, 0, 0, 1, '0, "R10");
    idle(4);
    check(sb.size() == 0, "R1", "all results seen", sb.size()[7:0], 8'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule